// File: doc/BRIEF.md
# Reconfigurable Multi-Precision Multiplier Array

This block is a 4W × 4W multiplier (32 × 32 with the default W = 8) built from nine identical small processing elements (PEs). A 3-bit mode word chooses the shape of each transaction. The array can compute up to nine independent W-bit products, up to three 2W-bit products, or a single 4W-bit product. A per-transaction flag selects unsigned or two's-complement signed arithmetic. Each PE multiplies two (W+1)-bit signed values, so the extra top bit carries the sign of an operand difference.

A 2W-bit product takes three PEs. Each operand is split into halves, X = XH·2^W + XL and Y = YH·2^W + YL. The middle term is found as XH·YH + XL·YL + (XH−XL)·(YL−YH), which avoids a fourth multiply. The 4W-bit product applies the same split one level up. Three groups of three PEs compute XL·YL, XH·YH and |XH−XL|·|YL−YH|. In signed modes the operands are first turned into magnitude and sign, and the product is negated when the two signs differ. PEs that the mode does not use keep their operand registers unchanged, so they do not switch. The set of active PEs is exported as an enable vector for power control.

There is no handshake. A transaction is presented with `in_valid` for one cycle and returns after a fixed latency in every mode.

Top module: `mpm_array`

## Requirements
- R1: The mode codes are: 0 = one W-bit lane, 1 = four W-bit lanes, 2 = nine W-bit lanes, 3 = one 2W-bit lane, 4 = two 2W-bit lanes, 5 = three 2W-bit lanes, 6 = one 4W-bit lane, 7 = reserved. For an n-bit mode, lane k takes bits [k·n +: n] of `in_a` and `in_b` and writes bits [k·2n +: 2n] of `out_result`.
- R2: With `in_signed` = 0, each active lane of the result holds the exact unsigned product of its two n-bit operands, 2n bits wide.
- R3: With `in_signed` = 1, each active lane treats its operands as n-bit two's complement and holds their product as 2n-bit two's complement. This includes the most negative value times itself.
- R4: Operands sampled at rising edge k produce `out_valid` = 1 and their result after rising edge k+1. `out_valid` after edge k+1 equals `in_valid` at edge k.
- R5: Result bits above the lanes that the mode uses are zero.
- R6: In reserved mode 7 a valid transaction still produces `out_valid` = 1, but `out_result` is all zero and no PE is enabled.
- R7: After the edge that samples a transaction, `pe_en` shows the PEs that transaction uses: mode 0 → 0x001, 1 → 0x00F, 3 → 0x007, 4 → 0x03F, 2/5/6 → 0x1FF, 7 → 0x000. `pe_en` is 0 after an edge with no transaction. A PE whose bit is 0 keeps its operands, and therefore its product, unchanged.
- R8: While `out_valid` is 0, `out_result` is all zero.
- R9: A synchronous active-high `rst` clears `out_valid`, `out_result` and `pe_en` on the next rising edge, even while `in_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A transaction is presented this cycle |
| in_mode | input | 3 | Mode code (R1) |
| in_signed | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| in_a | input | 9·W | Multiplicand lanes, least-significant lane first |
| in_b | input | 9·W | Multiplier lanes, least-significant lane first |
| out_valid | output | 1 | Result register holds a transaction |
| out_result | output | 18·W | Product lanes, least-significant lane first |
| pe_en | output | 9 | PEs loaded by the transaction now in the first stage |

## Verification
The bench builds the array with the default W = 8. This gives 72-bit operand buses, nine 8-bit lanes, three 16-bit lanes and one 32-bit lane. At this width the corner operands can be driven in every lane of every mode: zero, one, all ones, the most negative value and the largest positive value. These corners exercise the cases where an operand-half difference reaches ±255 and where magnitude conversion of the most negative value wraps. All eight mode codes are run in both signednesses, with idle cycles mixed in. A reset is also asserted in the middle of traffic.

// File: rtl/mpm_pkg.sv
package mpm_pkg;

  localparam int NPE  = 9;
  localparam int NGRP = 3;

  typedef enum logic [2:0] {
    MD_8X1  = 3'd0,
    MD_8X4  = 3'd1,
    MD_8X9  = 3'd2,
    MD_16X1 = 3'd3,
    MD_16X2 = 3'd4,
    MD_16X3 = 3'd5,
    MD_32X1 = 3'd6,
    MD_RSV  = 3'd7
  } mode_e;

  function automatic logic is_byte(mode_e m);
    return (m == MD_8X1) || (m == MD_8X4) || (m == MD_8X9);
  endfunction

  function automatic logic is_half(mode_e m);
    return (m == MD_16X1) || (m == MD_16X2) || (m == MD_16X3);
  endfunction

  function automatic logic is_word(mode_e m);
    return m == MD_32X1;
  endfunction

  function automatic int lane_cnt(mode_e m);
    case (m)
      MD_8X1:  return 1;
      MD_8X4:  return 4;
      MD_8X9:  return 9;
      MD_16X1: return 1;
      MD_16X2: return 2;
      MD_16X3: return 3;
      MD_32X1: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic [NPE-1:0] pe_mask(mode_e m);
    case (m)
      MD_8X1:  return 9'h001;
      MD_8X4:  return 9'h00F;
      MD_16X1: return 9'h007;
      MD_16X2: return 9'h03F;
      MD_8X9, MD_16X3, MD_32X1: return 9'h1FF;
      default: return 9'h000;
    endcase
  endfunction

endpackage

// File: rtl/mpm_distrib.sv
module mpm_distrib
  import mpm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  mode_e                  in_mode,
  input  logic                   in_signed,
  input  logic [NPE*W-1:0]       in_a,
  input  logic [NPE*W-1:0]       in_b,
  output logic [NPE-1:0][W:0]    pe_a,
  output logic [NPE-1:0][W:0]    pe_b,
  output logic [NPE-1:0]         lane_neg,
  output logic                   d32_neg,
  output mode_e                  mode_q,
  output logic                   vld_q,
  output logic [NPE-1:0]         pe_en
);

  localparam int P1 = W;
  localparam int P2 = 2 * W;
  localparam int P4 = 4 * W;

  logic [P1-1:0] m8a [NPE];
  logic [P1-1:0] m8b [NPE];
  logic [NPE-1:0] n8;
  logic [P2-1:0] m16a [NGRP];
  logic [P2-1:0] m16b [NGRP];
  logic [NGRP-1:0] n16;
  logic [P4-1:0] m32a, m32b;
  logic n32;
  logic [P2-1:0] xh, xl, yh, yl;
  logic [P2-1:0] ga [NGRP];
  logic [P2-1:0] gb [NGRP];
  logic dneg_nx;
  logic [NPE-1:0] neg_nx;
  logic [NPE-1:0][W:0] a_nx, b_nx;
  logic [NPE-1:0] mask_nx;

  // magnitude and sign of every lane at every width
  always_comb begin
    for (int k = 0; k < NPE; k++) begin
      m8a[k] = (in_signed && in_a[k*P1+P1-1]) ? (~in_a[k*P1 +: P1] + P1'(1)) : in_a[k*P1 +: P1];
      m8b[k] = (in_signed && in_b[k*P1+P1-1]) ? (~in_b[k*P1 +: P1] + P1'(1)) : in_b[k*P1 +: P1];
      n8[k]  = in_signed & (in_a[k*P1+P1-1] ^ in_b[k*P1+P1-1]);
    end
    for (int g = 0; g < NGRP; g++) begin
      m16a[g] = (in_signed && in_a[g*P2+P2-1]) ? (~in_a[g*P2 +: P2] + P2'(1)) : in_a[g*P2 +: P2];
      m16b[g] = (in_signed && in_b[g*P2+P2-1]) ? (~in_b[g*P2 +: P2] + P2'(1)) : in_b[g*P2 +: P2];
      n16[g]  = in_signed & (in_a[g*P2+P2-1] ^ in_b[g*P2+P2-1]);
    end
    m32a = (in_signed && in_a[P4-1]) ? (~in_a[P4-1:0] + P4'(1)) : in_a[P4-1:0];
    m32b = (in_signed && in_b[P4-1]) ? (~in_b[P4-1:0] + P4'(1)) : in_b[P4-1:0];
    n32  = in_signed & (in_a[P4-1] ^ in_b[P4-1]);
  end

  assign xh = m32a[P4-1:P2];
  assign xl = m32a[P2-1:0];
  assign yh = m32b[P4-1:P2];
  assign yl = m32b[P2-1:0];

  // per-group 2W-bit magnitude pairs; the full-width mode feeds the
  // three groups with low, high and difference halves
  always_comb begin
    dneg_nx = 1'b0;
    for (int g = 0; g < NGRP; g++) begin
      ga[g] = m16a[g];
      gb[g] = m16b[g];
    end
    if (is_word(in_mode)) begin
      ga[0]   = xl;
      gb[0]   = yl;
      ga[1]   = xh;
      gb[1]   = yh;
      ga[2]   = (xh >= xl) ? (xh - xl) : (xl - xh);
      gb[2]   = (yl >= yh) ? (yl - yh) : (yh - yl);
      dneg_nx = (xh < xl) ^ (yl < yh);
    end
    neg_nx = '0;
    if (is_byte(in_mode))      neg_nx = n8;
    else if (is_half(in_mode)) neg_nx[NGRP-1:0] = n16;
    else if (is_word(in_mode)) neg_nx[0] = n32;
  end

  // PE operands: three per group, or one lane per PE in byte modes
  always_comb begin
    for (int g = 0; g < NGRP; g++) begin
      a_nx[3*g]   = {1'b0, ga[g][P1-1:0]};
      b_nx[3*g]   = {1'b0, gb[g][P1-1:0]};
      a_nx[3*g+1] = {1'b0, ga[g][P2-1:P1]};
      b_nx[3*g+1] = {1'b0, gb[g][P2-1:P1]};
      a_nx[3*g+2] = {1'b0, ga[g][P2-1:P1]} - {1'b0, ga[g][P1-1:0]};
      b_nx[3*g+2] = {1'b0, gb[g][P1-1:0]} - {1'b0, gb[g][P2-1:P1]};
    end
    if (is_byte(in_mode)) begin
      for (int k = 0; k < NPE; k++) begin
        a_nx[k] = {1'b0, m8a[k]};
        b_nx[k] = {1'b0, m8b[k]};
      end
    end
  end

  assign mask_nx = pe_mask(in_mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      pe_a     <= '0;
      pe_b     <= '0;
      lane_neg <= '0;
      d32_neg  <= 1'b0;
      mode_q   <= MD_8X1;
      vld_q    <= 1'b0;
      pe_en    <= '0;
    end else begin
      vld_q <= in_valid;
      pe_en <= in_valid ? mask_nx : '0;
      if (in_valid) begin
        lane_neg <= neg_nx;
        d32_neg  <= dneg_nx;
        mode_q   <= in_mode;
      end
      for (int i = 0; i < NPE; i++) begin
        if (in_valid && mask_nx[i]) begin
          pe_a[i] <= a_nx[i];
          pe_b[i] <= b_nx[i];
        end
      end
    end
  end

  assert_reserved_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mode == MD_RSV) |=> (pe_en == '0))
    else $error("reserved mode enabled a PE");

endmodule

// File: rtl/mpm_pe.sv
module mpm_pe #(
  parameter int W = 8
) (
  input  logic [W:0]     a,
  input  logic [W:0]     b,
  output logic [2*W+1:0] p
);

  logic signed [2*W+1:0] ax, bx;

  assign ax = {{(W+1){a[W]}}, a};
  assign bx = {{(W+1){b[W]}}, b};
  assign p  = ax * bx;

endmodule

// File: rtl/mpm_collect.sv
module mpm_collect
  import mpm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NPE-1:0][2*W+1:0]  prod,
  input  logic [NPE-1:0]           lane_neg,
  input  logic                     d32_neg,
  input  mode_e                    mode_q,
  input  logic                     vld_q,
  output logic                     out_valid,
  output logic [2*NPE*W-1:0]       out_result
);

  localparam int P2    = 2 * W;
  localparam int P4    = 4 * W;
  localparam int P8    = 8 * W;
  localparam int OUT_W = 2 * NPE * W;

  logic signed [P2+3:0] eh [NGRP];
  logic signed [P2+3:0] el [NGRP];
  logic signed [P2+3:0] ed [NGRP];
  logic signed [P2+3:0] mg [NGRP];
  logic [P4-1:0] u [NGRP];
  logic [P4+2:0] m32;
  logic [P8-1:0] p64;
  logic [OUT_W-1:0] res_nx;
  mode_e out_mode;

  always_comb begin
    // 2W-bit magnitude product of each group from its three PEs
    for (int g = 0; g < NGRP; g++) begin
      el[g] = {{2{prod[3*g][P2+1]}},   prod[3*g]};
      eh[g] = {{2{prod[3*g+1][P2+1]}}, prod[3*g+1]};
      ed[g] = {{2{prod[3*g+2][P2+1]}}, prod[3*g+2]};
      mg[g] = eh[g] + el[g] + ed[g];
      u[g]  = P4'(prod[3*g]) + (P4'(mg[g]) << W) + (P4'(prod[3*g+1]) << P2);
    end
    // 4W-bit magnitude product from the three group products
    if (d32_neg) m32 = {3'b000, u[1]} + {3'b000, u[0]} - {3'b000, u[2]};
    else         m32 = {3'b000, u[1]} + {3'b000, u[0]} + {3'b000, u[2]};
    p64 = P8'(u[0]) + (P8'(m32) << P2) + (P8'(u[1]) << P4);

    res_nx = '0;
    if (is_byte(mode_q)) begin
      for (int k = 0; k < NPE; k++) begin
        if (k < lane_cnt(mode_q))
          res_nx[k*P2 +: P2] = lane_neg[k] ? (~prod[k][P2-1:0] + P2'(1)) : prod[k][P2-1:0];
      end
    end else if (is_half(mode_q)) begin
      for (int g = 0; g < NGRP; g++) begin
        if (g < lane_cnt(mode_q))
          res_nx[g*P4 +: P4] = lane_neg[g] ? (~u[g] + P4'(1)) : u[g];
      end
    end else if (is_word(mode_q)) begin
      res_nx[P8-1:0] = lane_neg[0] ? (~p64 + P8'(1)) : p64;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_mode   <= MD_8X1;
    end else begin
      out_valid  <= vld_q;
      out_result <= vld_q ? res_nx : '0;
      out_mode   <= mode_q;
    end
  end

  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_result == '0))
    else $error("result nonzero while idle");

  assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_mode == MD_RSV) |-> (out_result == '0))
    else $error("reserved mode produced a result");

  assert_word_upper_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_mode == MD_32X1) |-> (out_result[OUT_W-1:P8] == '0))
    else $error("unused lanes nonzero in full-width mode");

endmodule

// File: rtl/mpm_array.sv
module mpm_array
  import mpm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [2:0]            in_mode,
  input  logic                  in_signed,
  input  logic [NPE*W-1:0]      in_a,
  input  logic [NPE*W-1:0]      in_b,
  output logic                  out_valid,
  output logic [2*NPE*W-1:0]    out_result,
  output logic [NPE-1:0]        pe_en
);

  logic [NPE-1:0][W:0]     pe_a, pe_b;
  logic [NPE-1:0][2*W+1:0] prod;
  logic [NPE-1:0]          lane_neg;
  logic                    d32_neg;
  mode_e                   mode_q;
  logic                    vld_q;

  mpm_distrib #(.W(W)) i_distrib (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_mode   (mode_e'(in_mode)),
    .in_signed (in_signed),
    .in_a      (in_a),
    .in_b      (in_b),
    .pe_a      (pe_a),
    .pe_b      (pe_b),
    .lane_neg  (lane_neg),
    .d32_neg   (d32_neg),
    .mode_q    (mode_q),
    .vld_q     (vld_q),
    .pe_en     (pe_en)
  );

  for (genvar i = 0; i < NPE; i++) begin : g_pe
    mpm_pe #(.W(W)) i_pe (
      .a (pe_a[i]),
      .b (pe_b[i]),
      .p (prod[i])
    );

    assert_pe_hold_R7: assert property (@(posedge clk) disable iff (rst)
      !pe_en[i] |-> $stable(prod[i]))
      else $error("disabled PE %0d changed its product", i);
  end

  mpm_collect #(.W(W)) i_collect (
    .clk        (clk),
    .rst        (rst),
    .prod       (prod),
    .lane_neg   (lane_neg),
    .d32_neg    (d32_neg),
    .mode_q     (mode_q),
    .vld_q      (vld_q),
    .out_valid  (out_valid),
    .out_result (out_result)
  );

  // edges seen since reset, saturating, for the latency check
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                  since_rst <= 2'd0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end

  assert_latency_R4: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd2) |-> (out_valid == $past(in_valid, 2)))
    else $error("result valid does not follow input by two edges");

  assert_enable_shape_R7: assert property (@(posedge clk) disable iff (rst)
    ($countones(pe_en) == 0) || ($countones(pe_en) == 1) || ($countones(pe_en) == 3) ||
    ($countones(pe_en) == 4) || ($countones(pe_en) == 6) || ($countones(pe_en) == 9))
    else $error("illegal PE enable pattern");

endmodule

// File: tb/test_mpm_array.sv
module test_mpm_array;

  localparam int CLK_PERIOD = 10;
  localparam int W     = 8;
  localparam int IN_W  = 9 * W;
  localparam int OUT_W = 18 * W;

  logic             clk;
  logic             rst;
  logic             in_valid;
  logic [2:0]       in_mode;
  logic             in_signed;
  logic [IN_W-1:0]  in_a, in_b;
  logic             out_valid;
  logic [OUT_W-1:0] out_result;
  logic [8:0]       pe_en;

  int n_checks = 0;
  int n_fails  = 0;

  mpm_array #(.W(W)) i_mpm_array (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_mode    (in_mode),
    .in_signed  (in_signed),
    .in_a       (in_a),
    .in_b       (in_b),
    .out_valid  (out_valid),
    .out_result (out_result),
    .pe_en      (pe_en)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // reference pipeline: d1 = driven last step, d2 = the one before
  logic             d1_v, d2_v;
  logic [2:0]       d1_md, d2_md;
  logic             d2_sg, d1_sg;
  logic [OUT_W-1:0] d1_r, d2_r;

  function automatic int lane_w(logic [2:0] md);
    if (md <= 3'd2) return 8;
    if (md <= 3'd5) return 16;
    return 32;
  endfunction

  function automatic int lane_n(logic [2:0] md);
    case (md)
      3'd0: return 1;  3'd1: return 4;  3'd2: return 9;
      3'd3: return 1;  3'd4: return 2;  3'd5: return 3;
      3'd6: return 1;  default: return 0;
    endcase
  endfunction

  function automatic logic [8:0] exp_en(logic [2:0] md);
    case (md)
      3'd0: return 9'h001;  3'd1: return 9'h00F;  3'd3: return 9'h007;
      3'd4: return 9'h03F;  3'd7: return 9'h000;  default: return 9'h1FF;
    endcase
  endfunction

  function automatic logic [OUT_W-1:0] ref_mul(logic [2:0] md, logic sg,
                                                logic [IN_W-1:0] a, logic [IN_W-1:0] b);
    logic [OUT_W-1:0] r;
    logic [63:0] x, y, p, om, pm;
    int n;
    r  = '0;
    n  = lane_w(md);
    om = (64'd1 << n) - 64'd1;
    pm = (64'd1 << (2*n)) - 64'd1;
    for (int k = 0; k < lane_n(md); k++) begin
      x = 64'(a >> (k*n)) & om;
      y = 64'(b >> (k*n)) & om;
      if (sg && x[n-1]) x = x | ~om;
      if (sg && y[n-1]) y = y | ~om;
      p = (x * y) & pm;
      r = r | (OUT_W'(p) << (k*2*n));
    end
    return r;
  endfunction

  task automatic chk(string req, string what, logic [OUT_W-1:0] act, logic [OUT_W-1:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  task automatic check_outputs();
    int used;
    chk("R4", "out_valid", OUT_W'(out_valid), OUT_W'(d2_v));
    if (!d2_v)
      chk("R8", "idle result", out_result, '0);
    else if (d2_md == 3'd7)
      chk("R6", "reserved result", out_result, '0);
    else if (d2_sg)
      chk("R1,R3", "signed lanes", out_result, d2_r);
    else
      chk("R1,R2", "unsigned lanes", out_result, d2_r);
    if (d2_v && d2_md != 3'd7) begin
      used = lane_n(d2_md) * 2 * lane_w(d2_md);
      if (used < OUT_W)
        chk("R5", "unused lanes", out_result >> used, '0);
    end
    if (d1_v && d1_md == 3'd7)
      chk("R6", "reserved pe_en", OUT_W'(pe_en), '0);
    else
      chk("R7", "pe_en", OUT_W'(pe_en), OUT_W'(d1_v ? exp_en(d1_md) : 9'h000));
  endtask

  task automatic step(logic v, logic [2:0] md, logic sg, logic [IN_W-1:0] a, logic [IN_W-1:0] b);
    @(negedge clk);
    check_outputs();
    d2_v = d1_v;  d2_md = d1_md;  d2_sg = d1_sg;  d2_r = d1_r;
    in_valid  = v;
    in_mode   = md;
    in_signed = sg;
    in_a      = a;
    in_b      = b;
    d1_v  = v;
    d1_md = md;
    d1_sg = sg;
    d1_r  = ref_mul(md, sg, a, b);
  endtask

  function automatic logic [IN_W-1:0] rand_bus();
    return IN_W'({$urandom, $urandom, $urandom});
  endfunction

  function automatic logic [IN_W-1:0] add_corners(logic [IN_W-1:0] bus, logic [2:0] md);
    logic [IN_W-1:0] r, om, val;
    int n;
    r  = bus;
    n  = lane_w(md);
    om = (IN_W'(1) << n) - IN_W'(1);
    for (int k = 0; k < 9; k++) begin
      if (k * n < IN_W) begin
        case ($urandom % 6)
          0: val = '0;
          1: val = IN_W'(1);
          2: val = om;
          3: val = IN_W'(1) << (n-1);
          4: val = (IN_W'(1) << (n-1)) - IN_W'(1);
          default: val = r >> (k*n);
        endcase
        r = (r & ~(om << (k*n))) | ((val & om) << (k*n));
      end
    end
    return r;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_fails++;
    $display("FAIL R4 watchdog: actual hung expected completion");
    report();
  end

  initial begin
    logic [IN_W-1:0] a, b;
    rst = 1'b1;  in_valid = 1'b0;  in_mode = 3'd0;  in_signed = 1'b0;
    in_a = '0;   in_b = '0;
    d1_v = 1'b0; d2_v = 1'b0; d1_md = '0; d2_md = '0; d1_sg = 1'b0; d2_sg = 1'b0;
    d1_r = '0;   d2_r = '0;
    repeat (3) @(negedge clk);
    chk("R9", "reset out_valid", OUT_W'(out_valid), '0);
    chk("R9", "reset result", out_result, '0);
    chk("R9", "reset pe_en", OUT_W'(pe_en), '0);
    rst = 1'b0;

    for (int md = 0; md < 8; md++) begin
      for (int sg = 0; sg < 2; sg++) begin
        for (int it = 0; it < 150; it++) begin
          a = rand_bus();
          b = rand_bus();
          if (it < 50 || ($urandom % 3) == 0) begin
            a = add_corners(a, 3'(md));
            b = add_corners(b, 3'(md));
          end
          step(($urandom % 6) != 0, 3'(md), sg[0], a, b);
        end
      end
    end

    // most negative times itself in the full-width mode, back to back
    step(1'b1, 3'd6, 1'b1, IN_W'(32'h8000_0000), IN_W'(32'h8000_0000));
    step(1'b1, 3'd6, 1'b0, IN_W'(32'hFFFF_FFFF), IN_W'(32'hFFFF_FFFF));
    step(1'b1, 3'd5, 1'b1, {24'h0, 16'h8000, 16'h7FFF, 16'hFFFF}, {24'h0, 16'h8000, 16'h8000, 16'h0001});

    // reset in the middle of traffic
    @(negedge clk);
    check_outputs();
    rst = 1'b1;  in_valid = 1'b1;  in_mode = 3'd2;
    @(negedge clk);
    chk("R9", "mid reset out_valid", OUT_W'(out_valid), '0);
    chk("R9", "mid reset result", out_result, '0);
    chk("R9", "mid reset pe_en", OUT_W'(pe_en), '0);
    @(negedge clk);
    chk("R9", "held reset pe_en", OUT_W'(pe_en), '0);
    rst = 1'b0;  in_valid = 1'b0;
    d1_v = 1'b0;  d2_v = 1'b0;

    for (int it = 0; it < 40; it++)
      step(1'b1, 3'($urandom % 8), 1'($urandom), rand_bus(), rand_bus());
    step(1'b0, 3'd0, 1'b0, '0, '0);
    step(1'b0, 3'd0, 1'b0, '0, '0);
    step(1'b0, 3'd0, 1'b0, '0, '0);
    report();
  end

endmodule